// File: doc/BRIEF.md
# Legacy Memory-Map Attribute Decoder

This block classifies every processor memory request by address and by direction (read or write). For each request it decides whether the access is served by main DRAM or forwarded to the PCI bus, and whether the line may be held in the first-level and second-level caches. For DRAM accesses it also returns the physical DRAM address. That address is the request address itself, except in the alias windows above 256 MB, where it points back into low memory.

A small bank of byte-wide registers sets the decode. Software reaches them through a synchronous configuration port. The registers hold:

- per-segment read, write and cache permissions for the area from 640 KB to 1 MB;
- a memory-hole control that picks one of two alternative holes;
- a programmable top-of-DRAM;
- an alias control for system-management memory seen through the 256 MB to 512 MB window.

The decode result is registered and appears one clock after the request strobe.

Top module: `legacy_map_decoder`

## Requirements
- R1: `resp_valid` is high exactly in the cycle after a cycle with `req_valid` high. The result outputs change only in that cycle and otherwise hold their last values. The decode uses the register contents in force before any configuration write made in the same cycle as the request.
- R2: A write with `cfg_we` high loads `cfg_wdata` into the register at `cfg_addr` on the clock edge. `cfg_rdata` shows, one cycle later, the value the addressed register held before that edge. The register indices are: 0 = top attribute, 1–6 = paired attributes, 7 = hole control, 8 = top-of-DRAM, 9 = management alias control. Indices 10–15 read as zero, and writes to them are ignored.
- R3: After reset every register is zero, `resp_valid` and all result outputs are zero, and every request is forwarded to PCI.
- R4: Requests from 640 KB up to 768 KB always go to PCI and are uncacheable.
- R5: Each attribute field is 4 bits: bit 0 allows reads, bit 1 allows writes, bit 2 allows caching. Register 0 bits [3:0] govern 960 KB–1 MB. Register k (k = 1 to 6) governs two 16 KB segments starting at 768 KB + (k−1)·32 KB: bits [3:0] the lower one, bits [7:4] the upper one. A permitted access below top-of-DRAM goes to DRAM untranslated, with both cacheable outputs equal to the field's cache bit.
- R6: In 768 KB–1 MB, a read whose field has bit 0 clear, or a write whose field has bit 1 clear, goes to PCI and is uncacheable.
- R7: Register 7 bit 0 enables the memory hole. Bit 1 selects the hole: 0 = 512 KB–640 KB, 1 = 15 MB–16 MB. Requests in the enabled hole go to PCI. The hole that is not selected, or any hole while bit 0 is clear, decodes as ordinary memory.
- R8: Below top-of-DRAM and outside 640 KB–1 MB, the hole and the carved region, a request goes to DRAM untranslated. It is L1 cacheable, and L2 cacheable only below 64 MB.
- R9: Register 8 holds top-of-DRAM in 1 MB units. Any request from top-of-DRAM up to 256 MB goes to PCI.
- R10: With register 9 bit 0 set, requests at 256 MB + 640 KB up to 256 MB + 1 MB go to DRAM at the address minus 256 MB, and are uncacheable.
- R11: Register 9 bit 1 enables a management region at the top of DRAM. Register 9 bits [3:2] give its size: 0 = 128 KB, 1 = 256 KB, 2 = 512 KB, 3 = 1 MB. Its base is top-of-DRAM minus the size, floored at zero. Requests to the region's own addresses go to PCI. Requests at 256 MB plus the region's addresses go to DRAM at the address minus 256 MB, and are uncacheable.
- R12: All other requests at or above 256 MB go to PCI. In every result exactly one of `dram_sel` and `pci_sel` is high. A PCI result has both cacheable outputs low and `dram_addr` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 4 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Registered read-back of the indexed register |
| resp_valid | output | 1 | Result valid, one cycle after `req_valid` |
| dram_sel | output | 1 | Request served by DRAM |
| pci_sel | output | 1 | Request forwarded to PCI |
| l1_cacheable | output | 1 | First-level cacheable |
| l2_cacheable | output | 1 | Second-level cacheable |
| dram_addr | output | 32 | Translated DRAM address, zero for PCI |

## Verification
A corrupted register shows up on the first request into the region it governs. It appears as a wrong target or wrong cache flags in the result cycle, and as a wrong value on `cfg_rdata` one cycle after that register is indexed. A stuck or mis-timed result register shows up as `resp_valid` or result bits changing outside the cycle after a strobe. A bad alias subtraction shows up as a `dram_addr` that differs from the request address by something other than 256 MB. The bench compares every output on every clock against a behavioural model, so any such divergence is reported in the cycle it first appears.

// File: rtl/lmd_pkg.sv
// Package: shared address boundaries, register indices and field bit positions
// for the legacy memory-map decoder. Assumes 32-bit byte addresses.
package lmd_pkg;
    localparam logic [31:0] LOW_HOLE_BASE = 32'h0008_0000;  // 512 KB
    localparam logic [31:0] VGA_BASE      = 32'h000A_0000;  // 640 KB
    localparam logic [31:0] ATTR_BASE     = 32'h000C_0000;  // 768 KB
    localparam logic [31:0] TOP_SEG_BASE  = 32'h000F_0000;  // 960 KB
    localparam logic [31:0] ONE_MB        = 32'h0010_0000;
    localparam logic [31:0] HI_HOLE_BASE  = 32'h00F0_0000;  // 15 MB
    localparam logic [31:0] HI_HOLE_END   = 32'h0100_0000;  // 16 MB
    localparam logic [31:0] L2_LIMIT      = 32'h0400_0000;  // 64 MB
    localparam logic [31:0] ALIAS_BASE    = 32'h1000_0000;  // 256 MB
    localparam logic [31:0] ALIAS_END     = 32'h2000_0000;  // 512 MB

    localparam int MB_SHIFT   = 20;
    localparam int SEG_SHIFT  = 14;   // 16 KB attribute segments
    localparam int SEG_REGS   = 6;    // paired-attribute registers
    localparam int NUM_REGS   = 10;

    localparam int REG_TOP_ATTR = 0;
    localparam int REG_HOLE     = 7;
    localparam int REG_TOM      = 8;
    localparam int REG_SMM      = 9;

    localparam int FLD_RD = 0;
    localparam int FLD_WR = 1;
    localparam int FLD_CE = 2;

    localparam int HOLE_EN_BIT  = 0;
    localparam int HOLE_SEL_BIT = 1;
    localparam int SMM_LO_BIT   = 0;
    localparam int SMM_TOP_BIT  = 1;

    typedef enum logic { HOLE_LOW = 1'b0, HOLE_HIGH = 1'b1 } hole_sel_e;
endpackage

// File: rtl/lmd_cfg_regs.sv
// Configuration register bank. Writes land on the clock edge when cfg_we is
// high; read-back is registered and returns the pre-edge value. Indices at or
// above NUM_REGS read as zero and ignore writes.
module lmd_cfg_regs #(
    parameter int NUM_REGS = 10,
    parameter int CFG_AW   = 4,
    parameter int DATA_W   = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [CFG_AW-1:0]                cfg_addr,
    input  logic [DATA_W-1:0]                cfg_wdata,
    output logic [DATA_W-1:0]                cfg_rdata,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs
);
    logic [DATA_W-1:0] rd_next;

    // Register write: load the indexed entry, clear all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (cfg_addr == CFG_AW'(i)) regs[i] <= cfg_wdata;
            end
        end
    end

    // Read mux: select the indexed entry, zero for unmapped indices.
    always_comb begin
        rd_next = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (cfg_addr == CFG_AW'(i)) rd_next = regs[i];
        end
    end

    // Read-back register.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_rdata <= '0;
        else        cfg_rdata <= rd_next;
    end
endmodule

// File: rtl/lmd_attr_lookup.sv
// Attribute field selection for 768 KB - 1 MB. Returns the 4-bit field that
// governs the given address. Assumes the caller only uses the result when the
// address lies in that range.
module lmd_attr_lookup #(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 8,
    parameter int SEG_REGS = 6
) (
    input  logic [ADDR_W-1:0]              addr,
    input  logic [SEG_REGS:0][DATA_W-1:0]  attr_regs,
    output logic [DATA_W/2-1:0]            field
);
    import lmd_pkg::*;

    localparam int FIELD_W = DATA_W / 2;
    localparam int N_SEG   = 2 * SEG_REGS;
    localparam int IDX_W   = $clog2(N_SEG);
    localparam logic [ADDR_W-1:0] A_ATTR = ADDR_W'(ATTR_BASE);
    localparam logic [ADDR_W-1:0] A_TOPS = ADDR_W'(TOP_SEG_BASE);

    logic [FIELD_W-1:0] seg_field [N_SEG];
    logic [ADDR_W-1:0]  offset;
    logic [IDX_W-1:0]   idx;

    // Unpack each 16 KB segment's field from its register nibble.
    for (genvar s = 0; s < N_SEG; s++) begin : g_seg
        assign seg_field[s] = attr_regs[1 + s/2][FIELD_W*(s%2) +: FIELD_W];
    end

    assign offset = addr - A_ATTR;
    assign idx    = offset[SEG_SHIFT +: IDX_W];

    // Field select: top 64 KB from register 0, else the indexed segment.
    always_comb begin
        field = '0;
        if (addr >= A_TOPS) begin
            field = attr_regs[REG_TOP_ATTR][FIELD_W-1:0];
        end else begin
            for (int s = 0; s < N_SEG; s++) begin
                if (idx == IDX_W'(s)) field = seg_field[s];
            end
        end
    end
endmodule

// File: rtl/lmd_classify.sv
// Combinational region classifier. Applies, in priority order: the alias
// window above 256 MB, the legacy 640 KB - 1 MB area, the memory hole, the
// carved management region, top-of-DRAM, and ordinary DRAM.
// Assumes the attribute field has already been selected for the address.
module lmd_classify #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                write,
    input  logic [DATA_W/2-1:0] field,
    input  logic [DATA_W-1:0]   hole_ctl,
    input  logic [DATA_W-1:0]   tom,
    input  logic [DATA_W-1:0]   smm_ctl,
    output logic                hit_dram,
    output logic                hit_l1,
    output logic                hit_l2,
    output logic [ADDR_W-1:0]   xaddr
);
    import lmd_pkg::*;

    localparam logic [ADDR_W-1:0] A_LOWH  = ADDR_W'(LOW_HOLE_BASE);
    localparam logic [ADDR_W-1:0] A_VGA   = ADDR_W'(VGA_BASE);
    localparam logic [ADDR_W-1:0] A_ATTR  = ADDR_W'(ATTR_BASE);
    localparam logic [ADDR_W-1:0] A_1M    = ADDR_W'(ONE_MB);
    localparam logic [ADDR_W-1:0] A_HIH   = ADDR_W'(HI_HOLE_BASE);
    localparam logic [ADDR_W-1:0] A_HIHE  = ADDR_W'(HI_HOLE_END);
    localparam logic [ADDR_W-1:0] A_L2    = ADDR_W'(L2_LIMIT);
    localparam logic [ADDR_W-1:0] A_ALIAS = ADDR_W'(ALIAS_BASE);
    localparam logic [ADDR_W-1:0] A_AEND  = ADDR_W'(ALIAS_END);

    logic [ADDR_W-1:0] tom_bytes;
    logic [ADDR_W-1:0] carve_size;
    logic [ADDR_W-1:0] carve_base;
    logic [ADDR_W-1:0] phys;
    logic              allowed;
    logic              hole_hit;
    logic              carve_hit;
    hole_sel_e         hole_sel;

    // Top-of-DRAM in bytes and the carved region bounds.
    always_comb begin
        tom_bytes = ADDR_W'(tom) << MB_SHIFT;
        unique case (smm_ctl[3:2])
            2'd0:    carve_size = ADDR_W'(32'h0002_0000);
            2'd1:    carve_size = ADDR_W'(32'h0004_0000);
            2'd2:    carve_size = ADDR_W'(32'h0008_0000);
            default: carve_size = ADDR_W'(32'h0010_0000);
        endcase
        carve_base = (tom_bytes > carve_size) ? tom_bytes - carve_size : '0;
    end

    // Side conditions: permission, hole membership, carve membership.
    always_comb begin
        phys      = addr - A_ALIAS;
        allowed   = write ? field[FLD_WR] : field[FLD_RD];
        hole_sel  = hole_sel_e'(hole_ctl[HOLE_SEL_BIT]);
        hole_hit  = hole_ctl[HOLE_EN_BIT] &&
                    ((hole_sel == HOLE_LOW)  ? (addr >= A_LOWH && addr < A_VGA)
                                             : (addr >= A_HIH  && addr < A_HIHE));
        carve_hit = smm_ctl[SMM_TOP_BIT] && addr >= carve_base && addr < tom_bytes;
    end

    // Priority decode of target, cacheability and translated address.
    always_comb begin
        hit_dram = 1'b0;
        hit_l1   = 1'b0;
        hit_l2   = 1'b0;
        xaddr    = '0;
        if (addr >= A_ALIAS) begin
            if (addr < A_AEND) begin
                if (smm_ctl[SMM_LO_BIT] && phys >= A_VGA && phys < A_1M) begin
                    hit_dram = 1'b1;
                    xaddr    = phys;
                end else if (smm_ctl[SMM_TOP_BIT] && phys >= carve_base &&
                             phys < tom_bytes) begin
                    hit_dram = 1'b1;
                    xaddr    = phys;
                end
            end
        end else if (addr >= A_VGA && addr < A_1M) begin
            if (addr >= A_ATTR && addr < tom_bytes && allowed) begin
                hit_dram = 1'b1;
                hit_l1   = field[FLD_CE];
                hit_l2   = field[FLD_CE];
                xaddr    = addr;
            end
        end else if (!hole_hit && !carve_hit && addr < tom_bytes) begin
            hit_dram = 1'b1;
            hit_l1   = 1'b1;
            hit_l2   = (addr < A_L2);
            xaddr    = addr;
        end
    end
endmodule

// File: rtl/legacy_map_decoder.sv
// Top level: configuration bank, attribute lookup, classifier and the result
// register. A result is captured on each clock with req_valid high and is held
// until the next one. Assumes a synchronous active-low reset.
module legacy_map_decoder #(
    parameter int ADDR_W = 32,
    parameter int CFG_AW = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              resp_valid,
    output logic              dram_sel,
    output logic              pci_sel,
    output logic              l1_cacheable,
    output logic              l2_cacheable,
    output logic [ADDR_W-1:0] dram_addr
);
    import lmd_pkg::*;

    localparam int FIELD_W = DATA_W / 2;

    logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    logic [FIELD_W-1:0]              field;
    logic                            hit_dram, hit_l1, hit_l2;
    logic [ADDR_W-1:0]               xaddr;

    lmd_cfg_regs #(
        .NUM_REGS (NUM_REGS),
        .CFG_AW   (CFG_AW),
        .DATA_W   (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .regs      (regs)
    );

    lmd_attr_lookup #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SEG_REGS (SEG_REGS)
    ) u_attr (
        .addr      (req_addr),
        .attr_regs (regs[SEG_REGS:0]),
        .field     (field)
    );

    lmd_classify #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_cls (
        .addr     (req_addr),
        .write    (req_write),
        .field    (field),
        .hole_ctl (regs[REG_HOLE]),
        .tom      (regs[REG_TOM]),
        .smm_ctl  (regs[REG_SMM]),
        .hit_dram (hit_dram),
        .hit_l1   (hit_l1),
        .hit_l2   (hit_l2),
        .xaddr    (xaddr)
    );

    // Result register: capture the decode on a strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid   <= 1'b0;
            dram_sel     <= 1'b0;
            pci_sel      <= 1'b0;
            l1_cacheable <= 1'b0;
            l2_cacheable <= 1'b0;
            dram_addr    <= '0;
        end else begin
            resp_valid <= req_valid;
            if (req_valid) begin
                dram_sel     <= hit_dram;
                pci_sel      <= !hit_dram;
                l1_cacheable <= hit_l1;
                l2_cacheable <= hit_l2;
                dram_addr    <= xaddr;
            end
        end
    end
endmodule

// File: rtl/lmd_checker.sv
// Property checker for legacy_map_decoder, attached by bind below.
// Observes ports only.
module lmd_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              resp_valid,
    input logic              dram_sel,
    input logic              pci_sel,
    input logic              l1_cacheable,
    input logic              l2_cacheable,
    input logic [ADDR_W-1:0] dram_addr
);
    localparam logic [ADDR_W-1:0] C_VGA   = ADDR_W'(32'h000A_0000);
    localparam logic [ADDR_W-1:0] C_ATTR  = ADDR_W'(32'h000C_0000);
    localparam logic [ADDR_W-1:0] C_ALIAS = ADDR_W'(32'h1000_0000);
    localparam logic [ADDR_W-1:0] C_AEND  = ADDR_W'(32'h2000_0000);

    assert_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);
    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);
    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(dram_sel) && $stable(pci_sel) && $stable(dram_addr)
                        && $stable(l1_cacheable) && $stable(l2_cacheable)));
    assert_vga_pci_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr >= C_VGA && req_addr < C_ATTR) |=> pci_sel);
    assert_l2_implies_l1_R8: assert property (@(posedge clk) disable iff (!rst_n)
        l2_cacheable |-> l1_cacheable);
    assert_identity_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr < C_ALIAS) |=> (!dram_sel || dram_addr == $past(req_addr)));
    assert_alias_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr >= C_ALIAS) |=>
            (!dram_sel || (dram_addr == $past(req_addr) - C_ALIAS && !l1_cacheable)));
    assert_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (dram_sel != pci_sel));
    assert_pci_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
        pci_sel |-> (!l1_cacheable && !l2_cacheable && dram_addr == '0));
    assert_beyond_window_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr >= C_AEND) |=> pci_sel);
endmodule

bind legacy_map_decoder lmd_checker #(.ADDR_W(ADDR_W)) u_lmd_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .resp_valid   (resp_valid),
    .dram_sel     (dram_sel),
    .pci_sel      (pci_sel),
    .l1_cacheable (l1_cacheable),
    .l2_cacheable (l2_cacheable),
    .dram_addr    (dram_addr)
);

// File: tb/legacy_map_decoder_test.sv
// Bench: drives requests and configuration accesses at the falling edge and
// compares every output each cycle against a behavioural model.
module legacy_map_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        resp_valid, dram_sel, pci_sel, l1_cacheable, l2_cacheable;
    logic [31:0] dram_addr;

    int checks = 0;
    int fails  = 0;

    logic [7:0] mregs [10];
    bit         e_valid, e_dram, e_pci, e_l1, e_l2;
    logic [31:0] e_addr;
    logic [7:0]  e_rdata;
    string       e_tag;

    localparam longint KB = 1024;
    localparam longint MB = 1024 * 1024;

    always #2 clk = ~clk;   // 250 MHz

    legacy_map_decoder uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .resp_valid(resp_valid),
        .dram_sel(dram_sel), .pci_sel(pci_sel), .l1_cacheable(l1_cacheable),
        .l2_cacheable(l2_cacheable), .dram_addr(dram_addr)
    );

    // Behavioural model of the requirement text.
    function automatic void model(input logic [31:0] a, input bit w,
                                  output bit d, output bit c1, output bit c2,
                                  output logic [31:0] ta);
        longint ua   = longint'(a);
        longint tom  = longint'(mregs[8]) * MB;
        longint size = (128 * KB) << mregs[9][3:2];
        longint cb   = (tom > size) ? tom - size : 0;
        bit     carve_on = mregs[9][1];
        d = 0; c1 = 0; c2 = 0; ta = '0;
        if (ua >= 256 * MB) begin
            if (ua < 512 * MB) begin
                longint p = ua - 256 * MB;
                if ((mregs[9][0] && p >= 640 * KB && p < MB) ||
                    (carve_on && p >= cb && p < tom)) begin
                    d = 1; ta = 32'(p);
                end
            end
        end else if (ua >= 640 * KB && ua < MB) begin
            if (ua >= 768 * KB && ua < tom) begin
                logic [3:0] f;
                if (ua >= 960 * KB) f = mregs[0][3:0];
                else begin
                    int s = int'((ua - 768 * KB) / (16 * KB));
                    f = (s % 2 == 0) ? mregs[1 + s / 2][3:0] : mregs[1 + s / 2][7:4];
                end
                if (w ? f[1] : f[0]) begin
                    d = 1; c1 = f[2]; c2 = f[2]; ta = a;
                end
            end
        end else begin
            bit hole = mregs[7][0] && (mregs[7][1] ? (ua >= 15 * MB && ua < 16 * MB)
                                                   : (ua >= 512 * KB && ua < 640 * KB));
            bit carve = carve_on && ua >= cb && ua < tom;
            if (!hole && !carve && ua < tom) begin
                d = 1; c1 = 1; c2 = (ua < 64 * MB); ta = a;
            end
        end
    endfunction

    // One bench cycle: check last cycle's results, then drive new inputs.
    task automatic step(input bit rv, input logic [31:0] a, input bit w,
                        input bit we, input logic [3:0] ca, input logic [7:0] wd,
                        input string tag);
        bit d, c1, c2;
        logic [31:0] ta;
        @(negedge clk);
        checks++;
        if (resp_valid !== e_valid || dram_sel !== e_dram || pci_sel !== e_pci ||
            l1_cacheable !== e_l1 || l2_cacheable !== e_l2 || dram_addr !== e_addr) begin
            fails++;
            $display("FAIL %s: got v=%b d=%b p=%b l1=%b l2=%b a=%h exp v=%b d=%b p=%b l1=%b l2=%b a=%h",
                     e_tag, resp_valid, dram_sel, pci_sel, l1_cacheable, l2_cacheable,
                     dram_addr, e_valid, e_dram, e_pci, e_l1, e_l2, e_addr);
        end
        checks++;
        if (cfg_rdata !== e_rdata) begin
            fails++;
            $display("FAIL R2 (%s): cfg_rdata got %h exp %h", e_tag, cfg_rdata, e_rdata);
        end
        req_valid = rv; req_addr = a; req_write = w;
        cfg_we = we; cfg_addr = ca; cfg_wdata = wd;
        e_valid = rv;
        if (rv) begin
            model(a, w, d, c1, c2, ta);
            e_dram = d; e_pci = !d; e_l1 = c1; e_l2 = c2; e_addr = ta;
        end
        e_rdata = (ca < 4'd10) ? mregs[ca] : 8'h00;
        if (we && ca < 4'd10) mregs[ca] = wd;
        e_tag = tag;
    endtask

    task automatic rd(input logic [31:0] a, input string tag);
        step(1'b1, a, 1'b0, 1'b0, 4'd0, 8'h00, tag);
    endtask
    task automatic wr(input logic [31:0] a, input string tag);
        step(1'b1, a, 1'b1, 1'b0, 4'd0, 8'h00, tag);
    endtask
    task automatic cfg(input logic [3:0] ca, input logic [7:0] wd, input string tag);
        step(1'b0, 32'h0, 1'b0, 1'b1, ca, wd, tag);
    endtask
    task automatic peek(input logic [3:0] ca, input string tag);
        step(1'b0, 32'h0, 1'b0, 1'b0, ca, 8'h00, tag);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 10; i++) mregs[i] = 8'h00;
        e_valid = 0; e_dram = 0; e_pci = 0; e_l1 = 0; e_l2 = 0;
        e_addr = '0; e_rdata = '0; e_tag = "R3 reset";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R3: reset state, everything forwarded to PCI
        peek(4'd8, "R3 idle");
        rd(32'h0000_1000, "R3 low");
        rd(32'h000C_0000, "R3 attr");
        peek(4'd0, "R3 regs");

        // R2: register writes, read-back, unmapped index
        cfg(4'd8, 8'd128, "R2 tom");
        peek(4'd8, "R2 readback");
        cfg(4'd12, 8'hA5, "R2 unmapped");
        peek(4'd12, "R2 unmapped read");
        peek(4'd0, "R2 after");

        // R8, R9: ordinary memory and top-of-DRAM
        rd(32'h0000_1000, "R8 low");
        wr(32'h0500_0000, "R8 above 64M");
        peek(4'd0, "R1 hold");
        rd(32'h07FF_FFFC, "R9 below tom");
        rd(32'h0800_0000, "R9 at tom");
        rd(32'h0FFF_FFF0, "R9 below 256M");

        // R4: 640-768 KB
        cfg(4'd0, 8'h07, "R5 cfg");
        rd(32'h000A_0000, "R4 base");
        wr(32'h000B_FFFC, "R4 end");

        // R5, R6: attribute fields
        cfg(4'd1, 8'h31, "R5 cfg");
        cfg(4'd6, 8'h20, "R5 cfg");
        rd(32'h000F_8000, "R5 top cached");
        rd(32'h000C_0000, "R5 read only");
        wr(32'h000C_0000, "R6 write denied");
        wr(32'h000C_4000, "R5 rw uncached");
        wr(32'h000E_C000, "R5 write only");
        rd(32'h000E_C000, "R6 read denied");
        rd(32'h000E_8000, "R6 disabled");

        // R7: memory holes
        cfg(4'd7, 8'h01, "R7 cfg");
        rd(32'h0008_0000, "R7 low hole");
        rd(32'h0007_FFFC, "R7 below hole");
        rd(32'h00F0_0000, "R7 other hole");
        cfg(4'd7, 8'h03, "R7 cfg");
        rd(32'h00F0_0000, "R7 high hole");
        rd(32'h00FF_FFFC, "R7 high end");
        rd(32'h0100_0000, "R7 past hole");
        rd(32'h0008_0000, "R7 low off");
        cfg(4'd7, 8'h02, "R7 cfg");
        rd(32'h00F0_0000, "R7 disabled");

        // R10: legacy alias
        cfg(4'd9, 8'h01, "R10 cfg");
        rd(32'h100C_0000, "R10 alias");
        wr(32'h100F_FFFC, "R10 alias end");
        rd(32'h1009_FFFC, "R10 below");
        cfg(4'd9, 8'h00, "R10 cfg");
        rd(32'h100C_0000, "R10 off");

        // R11: carved region
        cfg(4'd9, 8'h0A, "R11 cfg");
        rd(32'h07F8_0000, "R11 carved");
        rd(32'h07F7_FFFC, "R11 below carve");
        rd(32'h17F8_0000, "R11 alias");
        rd(32'h1800_0000, "R11 past alias");
        cfg(4'd9, 8'h0E, "R11 cfg");
        rd(32'h07F0_0000, "R11 1MB carve");
        rd(32'h17F0_0000, "R11 1MB alias");

        // R12: beyond the window
        rd(32'h2000_0000, "R12 512M");
        wr(32'hFFFF_FFF0, "R12 top");

        // R1: write in the same cycle as a request uses old contents
        step(1'b1, 32'h0000_1000, 1'b0, 1'b1, 4'd8, 8'd0, "R1 same cycle");
        rd(32'h0000_1000, "R1 after write");

        // R12 sweep with random configuration
        for (int n = 0; n < 600; n++) begin
            int kind = int'($urandom % 5);
            logic [31:0] a;
            case (kind)
                0: a = $urandom % 32'h0010_0000;
                1: a = $urandom % 32'h0200_0000;
                2: a = 32'h1000_0000 + ($urandom % 32'h0800_0000);
                3: a = (32'(mregs[8]) << 20) - 32'h0010_0000 + ($urandom % 32'h0020_0000);
                default: a = $urandom;
            endcase
            if ($urandom % 4 == 0)
                step(1'b0, 32'h0, 1'b0, 1'b1, 4'($urandom % 16), 8'($urandom), "R2 sweep");
            else
                step(1'b1, a, 1'($urandom % 2), 1'b0, 4'($urandom % 16), 8'h00, "R12 sweep");
        end
        peek(4'd0, "R1 final");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule